// File: doc/BRIEF.md
# Burst Frame Sequencer

This block is the central state machine of a time-division-duplex timing engine. A global enable arms it. It then waits for a single-cycle sync pulse from an external sync source. If a startup delay is programmed, it counts that delay. It then runs a frame counter that wraps at the programmed frame length. Completed frames are counted against a burst setting. A nonzero burst stops the sequencer after exactly that many frames. A burst of zero lets frames repeat for as long as enable stays high.

The sequencer drives four outputs: the cycle position inside the current frame, a strobe on the first cycle of every frame, a running flag, and a two-bit state code for a status register. Downstream channel logic compares the frame position against its own on/off offsets.

The delay, frame length and burst settings are copied into shadow registers only while the sequencer is idle. Changes made to these inputs while the engine is enabled therefore have no effect until it has been stopped and re-armed.

Top module: `tdd_frame_seq`

## Requirements
- R1: After reset, state_code is 0, frame_cnt is 0, and frame_start and running are low.
- R2: The state code values are 0 = idle, 1 = armed (waiting for sync), 2 = startup delay and 3 = running. With enable high in idle and no completed burst pending, the state becomes armed on the next clock edge.
- R3: In the armed state the sequencer stays armed until sync_pulse is sampled high. A sync_pulse in any other state has no effect.
- R4: The edge that samples sync in the armed state starts the startup delay of D cycles. During those D cycles state_code is 2. When D is 0 the sequencer goes straight from armed to running.
- R5: In the running state frame_cnt starts at 0 and counts 0, 1, …, L-1 before wrapping to 0, where L is the frame length. A frame length of 0 behaves as 1.
- R6: running is high exactly while state_code is 3. frame_start is high exactly while running and frame_cnt is 0.
- R7: With a nonzero burst B, exactly B frames run. The sequencer returns to idle on the edge that ends the last cycle of frame B.
- R8: With a burst of 0, frames repeat without limit while enable stays high.
- R9: After a burst completes, the sequencer stays idle while enable remains high. It re-arms only after enable has been low for at least one edge.
- R10: When enable is sampled low in any state, the next cycle shows idle, frame_cnt 0 and running low.
- R11: Delay, frame length and burst are sampled only while idle. Changing these inputs in any other state does not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global engine enable |
| sync_pulse | input | 1 | Single-cycle sync event |
| delay_cfg | input | CNT_W | Startup delay in cycles |
| frame_len_cfg | input | CNT_W | Frame length in cycles |
| burst_cfg | input | BURST_W | Frames per burst, 0 = endless |
| frame_cnt | output | CNT_W | Cycle position within the current frame |
| frame_start | output | 1 | High on the first cycle of each frame |
| running | output | 1 | High while frames are running |
| state_code | output | 2 | Current state code |

## Verification
The bench sweeps delay 0 to 3, frame length 0 to 3 and burst 0 to 3. For each cycle after sync it derives state, count and strobe arithmetically.

An off-by-one in the delay would shift every frame by a cycle, and the position checks would catch it. Treating a zero frame length as a huge length would let the count run away. A burst counter that ends one frame early or late would show up as a wrong idle cycle.

Other corner cases target specific faults:
- Scrambling the configuration while armed catches a design that reads the live inputs instead of the shadows.
- A sync pulse injected mid-run would restart the frame count in a design that does not ignore it.
- Holding enable after a completed burst exposes a design that re-arms on its own.
- Dropping enable during the delay catches a design that leaves a counter uncleared.

// File: rtl/tdd_seq_pkg.sv
package tdd_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RUN   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/tdd_seq_timer.sv
module tdd_seq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         advance,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         last
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] count_d, count_q;

    // a limit of zero behaves as a limit of one
    assign last = (limit == '0) || (count_q == limit - ONE);

    always_comb begin
        count_d = count_q;
        if (clear)
            count_d = '0;
        else if (advance)
            count_d = last ? '0 : count_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

    // R5
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && limit != '0) |-> (count_q < limit));
endmodule

// File: rtl/tdd_seq_ctrl.sv
module tdd_seq_ctrl
    import tdd_seq_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int BURST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               sync_pulse,
    input  logic [CNT_W-1:0]   delay_cfg,
    input  logic [CNT_W-1:0]   frame_len_cfg,
    input  logic [BURST_W-1:0] burst_cfg,
    input  logic               delay_last,
    input  logic               frame_last,
    output seq_state_e         state,
    output logic [CNT_W-1:0]   delay_sh,
    output logic [CNT_W-1:0]   len_sh
);
    localparam logic [BURST_W-1:0] BONE = BURST_W'(1);

    typedef struct packed {
        seq_state_e         st;
        logic               done;
        logic [CNT_W-1:0]   dly;
        logic [CNT_W-1:0]   len;
        logic [BURST_W-1:0] bst;
        logic [BURST_W-1:0] frames;
    } ctrl_t;

    ctrl_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (d_q.st == ST_IDLE) begin
            d_d.dly = delay_cfg;
            d_d.len = frame_len_cfg;
            d_d.bst = burst_cfg;
        end
        case (d_q.st)
            ST_IDLE:  if (!d_q.done) d_d.st = ST_ARMED;
            ST_ARMED: if (sync_pulse) d_d.st = (d_q.dly == '0) ? ST_RUN : ST_WAIT;
            ST_WAIT:  if (delay_last) d_d.st = ST_RUN;
            ST_RUN: begin
                if (frame_last && d_q.bst != '0) begin
                    if (d_q.frames == d_q.bst - BONE) begin
                        d_d.st     = ST_IDLE;
                        d_d.done   = 1'b1;
                        d_d.frames = '0;
                    end else begin
                        d_d.frames = d_q.frames + BONE;
                    end
                end
            end
            default: d_d.st = ST_IDLE;
        endcase
        if (!enable) begin
            d_d.st     = ST_IDLE;
            d_d.done   = 1'b0;
            d_d.frames = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign state    = d_q.st;
    assign delay_sh = d_q.dly;
    assign len_sh   = d_q.len;

    // R10
    disable_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (d_q.st == ST_IDLE));

    // R3
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.st == ST_ARMED && enable && !sync_pulse) |=> (d_q.st == ST_ARMED));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.st == ST_IDLE && d_q.done && enable) |=> (d_q.st == ST_IDLE));

    // R11
    shadow_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.st != ST_IDLE) |=> ($stable(d_q.len) && $stable(d_q.dly) && $stable(d_q.bst)));

    // R4
    wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.st == ST_WAIT && !delay_last && enable) |=> (d_q.st == ST_WAIT));
endmodule

// File: rtl/tdd_frame_seq.sv
module tdd_frame_seq
    import tdd_seq_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int BURST_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               sync_pulse,
    input  logic [CNT_W-1:0]   delay_cfg,
    input  logic [CNT_W-1:0]   frame_len_cfg,
    input  logic [BURST_W-1:0] burst_cfg,
    output logic [CNT_W-1:0]   frame_cnt,
    output logic               frame_start,
    output logic               running,
    output logic [1:0]         state_code
);
    seq_state_e       state;
    logic [CNT_W-1:0] delay_sh, len_sh, delay_count;
    logic             delay_last, frame_last;

    tdd_seq_ctrl #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .sync_pulse    (sync_pulse),
        .delay_cfg     (delay_cfg),
        .frame_len_cfg (frame_len_cfg),
        .burst_cfg     (burst_cfg),
        .delay_last    (delay_last),
        .frame_last    (frame_last),
        .state         (state),
        .delay_sh      (delay_sh),
        .len_sh        (len_sh)
    );

    tdd_seq_timer #(.W(CNT_W)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!enable || state != ST_WAIT),
        .advance (state == ST_WAIT),
        .limit   (delay_sh),
        .count   (delay_count),
        .last    (delay_last)
    );

    tdd_seq_timer #(.W(CNT_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!enable || state != ST_RUN),
        .advance (state == ST_RUN),
        .limit   (len_sh),
        .count   (frame_cnt),
        .last    (frame_last)
    );

    assign running     = (state == ST_RUN);
    assign frame_start = running && (frame_cnt == '0);
    assign state_code  = state;

    // R4
    delay_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WAIT) |-> (delay_count == '0));
endmodule

// File: tb/tdd_frame_seq_test.sv
module tdd_frame_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          sync_pulse = 1'b0;
    logic [CW-1:0] delay_cfg = '0;
    logic [CW-1:0] frame_len_cfg = '0;
    logic [BW-1:0] burst_cfg = '0;
    logic [CW-1:0] frame_cnt;
    logic          frame_start, running;
    logic [1:0]    state_code;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdd_frame_seq #(.CNT_W(CW), .BURST_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sync_pulse(sync_pulse),
        .delay_cfg(delay_cfg), .frame_len_cfg(frame_len_cfg), .burst_cfg(burst_cfg),
        .frame_cnt(frame_cnt), .frame_start(frame_start), .running(running),
        .state_code(state_code)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_cfg(int d, int l, int b);
        int leff = (l == 0) ? 1 : l;
        int tend = (b != 0) ? d + b * leff + 3 : d + 2 * leff + 5;
        delay_cfg = CW'(d); frame_len_cfg = CW'(l); burst_cfg = BW'(b);
        enable = 1'b1;
        @(negedge clk);
        chk("R2 armed after enable", int'(state_code), 1);
        // R11: scramble the settings once armed
        delay_cfg = CW'(d + 7); frame_len_cfg = CW'(l + 5); burst_cfg = BW'(b + 3);
        repeat (2) begin
            @(negedge clk);
            chk("R3 armed holds without sync", int'(state_code), 1);
        end
        sync_pulse = 1'b1;
        @(negedge clk);
        sync_pulse = 1'b0;
        for (int t = 0; t <= tend; t++) begin
            int r = t - d;
            int est, ecnt, estart;
            string tag;
            if (t < d) begin
                est = 2; ecnt = 0; estart = 0; tag = "R4 delay";
            end else if (b != 0 && r >= b * leff) begin
                est = 0; ecnt = 0; estart = 0; tag = "R7 R9 burst end";
            end else begin
                est = 3; ecnt = r % leff; estart = (ecnt == 0) ? 1 : 0;
                tag = (b == 0) ? "R8 endless R11" : "R7 burst R11";
            end
            chk(tag, int'(state_code), est);
            chk("R5 frame count", int'(frame_cnt), ecnt);
            chk("R6 frame strobe", int'(frame_start), estart);
            chk("R6 running flag", int'(running), (est == 3) ? 1 : 0);
            // R3: a sync pulse outside the armed state is ignored
            sync_pulse = (t == d + 1);
            @(negedge clk);
        end
        sync_pulse = 1'b0;
        enable = 1'b0;
        @(negedge clk);
        chk("R10 idle after disable", int'(state_code), 0);
        chk("R10 count cleared", int'(frame_cnt), 0);
        chk("R10 running low", int'(running), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", int'(state_code), 0);
        chk("R1 reset count", int'(frame_cnt), 0);
        chk("R1 reset strobe", int'(frame_start), 0);
        chk("R1 reset running", int'(running), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", int'(state_code), 0);

        for (int d = 0; d < 4; d++)
            for (int l = 0; l < 4; l++)
                for (int b = 0; b < 4; b++)
                    run_cfg(d, l, b);

        // R10: abort during the startup delay
        delay_cfg = CW'(6); frame_len_cfg = CW'(2); burst_cfg = '0;
        enable = 1'b1;
        @(negedge clk);
        sync_pulse = 1'b1;
        @(negedge clk);
        sync_pulse = 1'b0;
        @(negedge clk);
        chk("R4 in delay before abort", int'(state_code), 2);
        enable = 1'b0;
        @(negedge clk);
        chk("R10 abort from delay", int'(state_code), 0);
        // the same settings again must give a full delay
        enable = 1'b1;
        @(negedge clk);
        chk("R9 rearm after enable cycle", int'(state_code), 1);
        sync_pulse = 1'b1;
        @(negedge clk);
        sync_pulse = 1'b0;
        repeat (5) @(negedge clk);
        chk("R4 delay restarted from zero", int'(state_code), 2);
        @(negedge clk);
        chk("R4 delay ends after six cycles", int'(state_code), 3);
        enable = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule